// File: doc/BRIEF.md
# DVMA Page Translation Engine

This block turns device virtual addresses of DMA transfers into 36-bit physical addresses. It looks each one up in a single-level page table kept in system memory. A transfer request carries a start address, a byte length and a direction. The engine walks the transfer one 4 KB page at a time. For each page it forms the address of the page-table entry from a base register and a configurable window size. It reads the 32-bit entry over a request/acknowledge memory port, checks the entry's permission bits, and returns either a physical chunk (address and byte count) or a fault.

A fault ends the walk. It also hands the register file a ready-made status word, the page-aligned failing address and a one-cycle interrupt strobe. When translation is switched off, chunks pass through with the device address zero-extended to 36 bits and no table access. The base, window and enable settings are captured when a request is accepted and stay fixed for that transfer.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_req` and `flt_strobe` are 0.
- R2: With the window code `w` (0..7, window size 16 MB << w), the entry address is `{cfg_base, 4'b0}` plus ((the device address with all bits at and above position 24+w cleared) >> 10, with its two low bits forced to 0). The entry address is always word aligned.
- R3: For a valid entry, the physical address is the entry's bits [31:8] placed at physical bits [35:12], plus the 12-bit in-page offset of the current address.
- R4: A transfer is split into chunks. Each chunk runs from the current address to the next 4 KB boundary or to the end of the transfer, whichever comes first. Chunks are reported in address order, and `rsp_last` marks the final one.
- R5: An entry whose valid bit (bit 1) is 0 gives a fault response for that page, for reads and writes alike.
- R6: A write to a page whose entry has its write-permitted bit (bit 2) at 0 faults. A read of such a page translates normally.
- R7: On a fault, `flt_strobe` pulses together with the fault response. `flt_status` has bits 31, 30, 23 and 17 set, plus bit 18 for a read, and all other bits 0. `flt_addr` is the current address with bits [11:0] cleared. A fault response has `rsp_pa` and `rsp_len` at 0.
- R8: The walk stops at the first faulting page. The fault response carries `rsp_last`=1, and no further chunk of that transfer is reported.
- R9: When `cfg_enable` is 0 at acceptance, each chunk's physical address is the device address zero-extended to 36 bits, and no memory fetch is made.
- R10: From the acceptance of a non-empty transfer until its last or faulting response, `req_ready` stays 0.
- R11: A request of length 0 is accepted, produces no response, and leaves `req_ready` at 1.
- R12: Once raised, `mem_req` stays high with an unchanged `mem_addr` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Translation on (1) or pass-through (0) |
| cfg_window | input | 3 | Window size code, 16 MB << code |
| cfg_base | input | 32 | Page-table base, shifted left by 4 to form a byte address |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Engine idle and able to accept |
| req_addr | input | 32 | Device virtual start address |
| req_len | input | 16 | Transfer length in bytes |
| req_write | input | 1 | 1 for a device write to memory |
| mem_req | output | 1 | Entry fetch request |
| mem_addr | output | 36 | Entry byte address |
| mem_ack | input | 1 | Fetch complete, `mem_rdata` valid |
| mem_rdata | input | 32 | Fetched page-table entry |
| rsp_valid | output | 1 | One chunk or fault reported this cycle |
| rsp_pa | output | 36 | Physical address of the chunk |
| rsp_len | output | 13 | Chunk length in bytes |
| rsp_fault | output | 1 | Chunk faulted |
| rsp_last | output | 1 | Final response of the transfer |
| flt_strobe | output | 1 | One-cycle interrupt raise |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Page-aligned failing address |

## Verification
The engine is driven with random transfers covering every window code, random base values, both directions and lengths from empty to more than two pages. The entry values come from an address hash, so a wrong entry address shows up as a wrong physical page, and forced flag modes separate valid-bit faults from write-permission faults. Directed cases cover pass-through across a page boundary, a one-byte offset before a boundary, a transfer of exactly one aligned page, and a read of a read-only page against a write to it. They also cover the empty request, which tells a silent accept apart from a spurious response. Fetch latency is randomised so that the held request address is observed over several wait cycles.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  localparam int PAGE_BITS = 12;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPLIT = 2'd1,
    ST_FETCH = 2'd2
  } walk_st_e;

  // fault status pieces: error, late error, reserved-one, address valid
  localparam logic [31:0] FLT_BASE_WORD = 32'hC082_0000;
  localparam logic [31:0] FLT_READ_BIT  = 32'h0004_0000;

  // entry flag positions
  localparam int PTE_VLD_POS = 1;
  localparam int PTE_WR_POS  = 2;
endpackage

// File: rtl/dvma_pte_addr.sv
module dvma_pte_addr #(
  parameter int ADDR_W       = 32,
  parameter int MIN_WIN_BITS = 24,
  localparam int PA_W        = ADDR_W + 4,
  localparam int HI_W        = ADDR_W - dvma_pkg::PAGE_BITS
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [HI_W-1:0]   dva_page,
  input  logic [2:0]        win,
  output logic [PA_W-1:0]   pte_addr
);
  logic [HI_W-1:0] keep_mask;
  logic [HI_W-1:0] idx;

  always_comb begin
    // bits at or above the window size are dropped
    keep_mask = ~({HI_W{1'b1}} << (MIN_WIN_BITS - dvma_pkg::PAGE_BITS + int'(win)));
    idx       = dva_page & keep_mask;
    pte_addr  = {base, 4'b0000} + PA_W'({idx, 2'b00});
  end
endmodule

// File: rtl/dvma_chunk_calc.sv
module dvma_chunk_calc #(
  parameter int LEN_W     = 16,
  localparam int CHUNK_W  = dvma_pkg::PAGE_BITS + 1
) (
  input  logic [dvma_pkg::PAGE_BITS-1:0] page_off,
  input  logic [LEN_W-1:0]               remain,
  output logic [CHUNK_W-1:0]             chunk_len,
  output logic                           chunk_last
);
  logic [CHUNK_W-1:0] room;

  always_comb begin
    room       = CHUNK_W'(dvma_pkg::PAGE_BYTES) - {1'b0, page_off};
    chunk_last = (remain <= LEN_W'(room));
    chunk_len  = chunk_last ? remain[CHUNK_W-1:0] : room;
  end
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check (
  input  logic [23:0]                    pte_page,
  input  logic                           pte_vld,
  input  logic                           pte_wr,
  input  logic                           is_write,
  input  logic [dvma_pkg::PAGE_BITS-1:0] page_off,
  output logic                           ok,
  output logic [35:0]                    pa,
  output logic [31:0]                    status
);
  always_comb begin
    ok     = pte_vld && (pte_wr || !is_write);
    pa     = {pte_page, page_off};
    status = dvma_pkg::FLT_BASE_WORD | (is_write ? 32'h0 : dvma_pkg::FLT_READ_BIT);
  end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate #(
  parameter int ADDR_W       = 32,
  parameter int LEN_W        = 16,
  parameter int MIN_WIN_BITS = 24,
  localparam int PA_W        = ADDR_W + 4,
  localparam int CHUNK_W     = dvma_pkg::PAGE_BITS + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_enable,
  input  logic [2:0]         cfg_window,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_write,
  output logic               mem_req,
  output logic [PA_W-1:0]    mem_addr,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_pa,
  output logic [CHUNK_W-1:0] rsp_len,
  output logic               rsp_fault,
  output logic               rsp_last,
  output logic               flt_strobe,
  output logic [31:0]        flt_status,
  output logic [ADDR_W-1:0]  flt_addr
);
  import dvma_pkg::*;

  walk_st_e           state;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   remain;
  logic               wr_q;
  logic               xl_q;
  logic [2:0]         win_q;
  logic [ADDR_W-1:0]  base_q;

  logic [PA_W-1:0]    pte_addr;
  logic [CHUNK_W-1:0] clen;
  logic               clast;
  logic               chk_ok;
  logic [35:0]        chk_pa;
  logic [31:0]        chk_status;
  logic [PA_W-1:0]    out_pa;
  logic               pte_unused;

  assign pte_unused = ^{mem_rdata[7:3], mem_rdata[0]};

  dvma_pte_addr #(.ADDR_W(ADDR_W), .MIN_WIN_BITS(MIN_WIN_BITS)) i_pte_addr (
    .base     (base_q),
    .dva_page (cur_addr[ADDR_W-1:PAGE_BITS]),
    .win      (win_q),
    .pte_addr (pte_addr)
  );

  dvma_chunk_calc #(.LEN_W(LEN_W)) i_chunk (
    .page_off   (cur_addr[PAGE_BITS-1:0]),
    .remain     (remain),
    .chunk_len  (clen),
    .chunk_last (clast)
  );

  dvma_pte_check i_check (
    .pte_page (mem_rdata[31:8]),
    .pte_vld  (mem_rdata[PTE_VLD_POS]),
    .pte_wr   (mem_rdata[PTE_WR_POS]),
    .is_write (wr_q),
    .page_off (cur_addr[PAGE_BITS-1:0]),
    .ok       (chk_ok),
    .pa       (chk_pa),
    .status   (chk_status)
  );

  assign out_pa = xl_q ? PA_W'(chk_pa) : PA_W'(cur_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_ready  <= 1'b1;
      cur_addr   <= '0;
      remain     <= '0;
      wr_q       <= 1'b0;
      xl_q       <= 1'b0;
      win_q      <= '0;
      base_q     <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_len    <= '0;
      rsp_fault  <= 1'b0;
      rsp_last   <= 1'b0;
      flt_strobe <= 1'b0;
      flt_status <= '0;
      flt_addr   <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      flt_strobe <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_addr <= req_addr;
            remain   <= req_len;
            wr_q     <= req_write;
            xl_q     <= cfg_enable;
            win_q    <= cfg_window;
            base_q   <= cfg_base;
            if (req_len != '0) begin
              req_ready <= 1'b0;
              state     <= ST_SPLIT;
            end
          end
        end
        ST_SPLIT, ST_FETCH: begin
          if (state == ST_SPLIT && xl_q) begin
            mem_req  <= 1'b1;
            mem_addr <= pte_addr;
            state    <= ST_FETCH;
          end else if (state == ST_SPLIT || mem_ack) begin
            mem_req   <= 1'b0;
            rsp_valid <= 1'b1;
            if (xl_q && !chk_ok) begin
              rsp_pa     <= '0;
              rsp_len    <= '0;
              rsp_fault  <= 1'b1;
              rsp_last   <= 1'b1;
              flt_strobe <= 1'b1;
              flt_status <= chk_status;
              flt_addr   <= {cur_addr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
              req_ready  <= 1'b1;
              state      <= ST_IDLE;
            end else begin
              rsp_pa    <= out_pa;
              rsp_len   <= clen;
              rsp_fault <= 1'b0;
              rsp_last  <= clast;
              cur_addr  <= cur_addr + ADDR_W'(clen);
              remain    <= remain - LEN_W'(clen);
              if (clast) begin
                req_ready <= 1'b1;
                state     <= ST_IDLE;
              end else begin
                state <= ST_SPLIT;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R12
  AST_PTE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready); // R10
  AST_CHUNK_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_len != '0 &&
      ({1'b0, rsp_pa[PAGE_BITS-1:0]} + rsp_len) <= CHUNK_W'(PAGE_BYTES)); // R4
  AST_FAULT_ENDS_WALK: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_last && flt_strobe); // R8
  AST_FAULT_WORD: assert property (@(posedge clk) disable iff (rst)
    flt_strobe |-> flt_status[31] && flt_status[30] && flt_status[23] && flt_status[17]); // R7
  AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_last |-> req_ready); // R10
endmodule

// File: tb/test_dvma_xlate.sv
module test_dvma_xlate;
  typedef struct packed {
    logic [35:0] pa;
    logic [12:0] len;
    logic        fault;
    logic        last;
    logic [31:0] st;
    logic [31:0] fa;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [2:0]  cfg_window = '0;
  logic [31:0] cfg_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        req_write = 1'b0;
  logic        mem_req;
  logic [35:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [35:0] rsp_pa;
  logic [12:0] rsp_len;
  logic        rsp_fault;
  logic        rsp_last;
  logic        flt_strobe;
  logic [31:0] flt_status;
  logic [31:0] flt_addr;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  bit    force_v = 1'b1;
  bit    force_w = 1'b1;
  string cur_tag = "R1";
  exp_t  expq[$];

  always #2 clk = ~clk;

  dvma_xlate i_dvma_xlate (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_window(cfg_window),
    .cfg_base(cfg_base), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_len(rsp_len), .rsp_fault(rsp_fault),
    .rsp_last(rsp_last), .flt_strobe(flt_strobe), .flt_status(flt_status),
    .flt_addr(flt_addr)
  );

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // table contents: hashed word with optional forced flags
  function automatic logic [31:0] pte_of(logic [35:0] a);
    logic [31:0] h;
    h = (a[35:4] ^ a[31:0]) * 32'h9E37_79B1;
    h = h ^ (h >> 15);
    if (force_v) h[1] = 1'b1;
    if (force_w) h[2] = 1'b1;
    return h;
  endfunction

  task automatic build_expect(logic [31:0] a, logic [15:0] n, bit wr, bit en,
                              logic [2:0] w, logic [31:0] base);
    logic [31:0] cur = a;
    int          rem = n;
    while (rem > 0) begin
      int          room = 4096 - int'(cur[11:0]);
      int          l    = (rem < room) ? rem : room;
      bit          lst  = (rem <= room);
      exp_t        e;
      logic [63:0] lim  = (64'd1 << (24 + w)) - 64'd1;
      logic [35:0] ea;
      logic [31:0] pte;
      e = '0;
      if (!en) begin
        e.pa = {4'h0, cur}; e.len = 13'(l); e.last = lst;
      end else begin
        ea  = {base, 4'h0} + 36'(((64'(cur) & lim) >> 10) & ~64'd3);
        pte = pte_of(ea);
        if (!pte[1] || (wr && !pte[2])) begin
          e.fault = 1'b1; e.last = 1'b1;
          e.st = 32'h8000_0000 | 32'h4000_0000 | 32'h0080_0000 | 32'h0002_0000 |
                 (wr ? 32'h0 : 32'h0004_0000);
          e.fa = cur & 32'hFFFF_F000;
          expq.push_back(e);
          return;
        end
        e.pa = {pte[31:8], 12'h000} + 36'(cur[11:0]); e.len = 13'(l); e.last = lst;
      end
      expq.push_back(e);
      cur = cur + 32'(l);
      rem = rem - l;
    end
  endtask

  // response checker
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (rsp_valid) begin
          if (expq.size() == 0) begin
            check(1'b0, "R4 unexpected response", 128'(rsp_pa), 128'(0));
          end else begin
            exp_t e;
            e = expq.pop_front();
            check({rsp_pa, rsp_len, rsp_fault, rsp_last} == {e.pa, e.len, e.fault, e.last},
                  {cur_tag, " chunk"}, {rsp_pa, rsp_len, rsp_fault, rsp_last},
                  {e.pa, e.len, e.fault, e.last});
            if (e.fault)
              check(flt_strobe && flt_status == e.st && flt_addr == e.fa, "R7 fault word",
                    {flt_strobe, flt_status, flt_addr}, {1'b1, e.st, e.fa});
          end
        end else if (flt_strobe) begin
          check(1'b0, "R7 stray strobe", 128'(flt_status), 128'(0));
        end
      end
    end
  end

  // entry memory with random latency
  initial begin
    bit          busy = 1'b0;
    int          dly = 0;
    logic [35:0] lat = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && !rst) begin
        if (!busy) begin
          busy = 1'b1; lat = mem_addr; dly = $urandom_range(0, 3);
          check(!cfg_enable_seen_off(), "R9 fetch in pass-through", 128'(1), 128'(0));
        end else begin
          check(mem_addr == lat, "R12 held fetch address", 128'(mem_addr), 128'(lat));
        end
        if (dly == 0) begin
          mem_ack = 1'b1; mem_rdata = pte_of(lat); busy = 1'b0;
        end else begin
          dly--;
        end
      end
    end
  end

  bit pass_mode = 1'b0;
  function automatic bit cfg_enable_seen_off();
    return pass_mode;
  endfunction

  task automatic xfer(logic [31:0] a, logic [15:0] n, bit wr, bit en, logic [2:0] w,
                      logic [31:0] base, string tag);
    int guard = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_tag    = tag;
    pass_mode  = !en;
    cfg_enable = en; cfg_window = w; cfg_base = base;
    req_addr   = a;  req_len = n;    req_write = wr;
    build_expect(a, n, wr, en, w, base);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (n == 0) begin
      check(req_ready == 1'b1, "R11 ready after empty request", 128'(req_ready), 128'(1));
      repeat (3) @(negedge clk);
    end else begin
      check(req_ready == 1'b0, "R10 busy after accept", 128'(req_ready), 128'(0));
      while (!(expq.size() == 0 && req_ready) && guard < 2000) begin
        @(negedge clk);
        guard++;
      end
    end
    check(expq.size() == 0, {tag, " all responses seen"}, 128'(expq.size()), 128'(0));
    expq.delete();
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req && !flt_strobe, "R1 reset state",
          {req_ready, rsp_valid, mem_req, flt_strobe}, 4'b1000);

    // R9 pass-through, crossing a boundary
    xfer(32'h1234_5F80, 16'd300, 1'b0, 1'b0, 3'd0, 32'h0, "R9");
    // R4 one byte before a boundary, two chunks
    xfer(32'h0000_0FFF, 16'd2, 1'b1, 1'b0, 3'd2, 32'h0, "R4");
    // R4 exactly one aligned page
    force_v = 1'b1; force_w = 1'b1;
    xfer(32'hFF12_3000, 16'd4096, 1'b1, 1'b1, 3'd0, 32'h0001_0000, "R4");
    // R2 R3 multi-page translated walk, several windows
    xfer(32'hFF12_3456, 16'd9000, 1'b0, 1'b1, 3'd0, 32'h0001_0000, "R2");
    xfer(32'h8765_4321, 16'd5000, 1'b1, 1'b1, 3'd7, 32'h0ABC_D400, "R3");
    // R6 read-only pages: read passes, write faults on first page
    force_w = 1'b0;
    for (int k = 0; k < 4; k++)
      xfer(32'h0040_0000 + 32'(k) * 32'h1000, 16'd100, 1'b0, 1'b1, 3'd1, 32'h0002_0000, "R6");
    for (int k = 0; k < 4; k++)
      xfer(32'h0040_0000 + 32'(k) * 32'h1000, 16'd100, 1'b1, 1'b1, 3'd1, 32'h0002_0000, "R6");
    // R5 R8 hashed valid bits, walks that stop midway
    force_v = 1'b0; force_w = 1'b1;
    for (int k = 0; k < 6; k++)
      xfer(32'h0100_0800 + 32'(k) * 32'h3000, 16'd12000, 1'b0, 1'b1, 3'd3, 32'h0003_0000, "R8");
    xfer(32'h0000_1000, 16'd64, 1'b1, 1'b1, 3'd0, 32'h0000_0000, "R5");
    // R11 empty request
    xfer(32'h0000_2000, 16'd0, 1'b0, 1'b1, 3'd0, 32'h0, "R11");

    // constrained random mix
    for (int k = 0; k < 80; k++) begin
      logic [31:0] a  = $urandom();
      logic [15:0] n  = 16'($urandom_range(0, 9000));
      bit          wr = 1'($urandom_range(0, 1));
      bit          en = ($urandom_range(0, 4) != 0);
      logic [2:0]  w  = 3'($urandom_range(0, 7));
      logic [31:0] b  = $urandom() & 32'h07FF_FC00;
      force_v = ($urandom_range(0, 3) != 0);
      force_w = ($urandom_range(0, 2) != 0);
      xfer(a, n, wr, en, w, b, en ? "R3" : "R9");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10 engine hung actual=busy expected=idle");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule